// File: doc/BRIEF.md
# Branch Resolution and Interworking Unit

This block finishes off an already-decoded control-transfer operation for a core that can run in four execution states. These are a fixed-width state (every instruction is 4 bytes), a compact state (instructions of 2 or 4 bytes), a bytecode state, and a restricted compact-extension state. Each cycle that `opValid` is high, the unit takes the operation kind, its condition code, the current flags, the state, the PC, the instruction size, a sign-extended immediate displacement and a register operand. It decides whether the transfer happens.

One clock edge later it presents the next PC, the next execution state, a link-register write strobe with its data, and a fault flag. A transfer whose condition fails, or which faults, falls through to the next sequential instruction. It then leaves the state as it was and writes no link.

The flags are an input only. No path in the unit produces new flag values. Fetch, decode and the pipeline flush sit around the unit and are not part of it.

Top module: `br_resolve_top`

Encodings used at the ports:
- `opKind`: 0 relative jump, 1 relative call, 2 register jump, 3 relative call with state swap, 4 register call, 5 register jump into bytecode state. Codes 6 and 7 are illegal.
- `curState` and `nextState`: 0 fixed-width, 1 compact, 2 bytecode, 3 compact-extension.
- `condFlags`: bit 3 negative, bit 2 zero, bit 1 carry, bit 0 overflow.

## Requirements
- R1: `condCode` is checked against `condFlags` with the standard 4-bit table. The codes are 0 zero set, 1 zero clear, 2 carry set, 3 carry clear, 4 negative set, 5 negative clear, 6 overflow set, 7 overflow clear, 8 carry set and zero clear, 9 carry clear or zero set, 10 negative equals overflow, 11 negative differs from overflow, 12 zero clear and negative equals overflow, 13 zero set or negative differs from overflow. Codes 14 and 15 always pass. On a failed condition: `brTaken`=0, `fault`=0, `linkWe`=0, `nextPc` = PC plus instruction size, and `nextState` = `curState`.
- R2: Kinds 1, 3 and 4, when taken, assert `linkWe` with `linkData` = PC plus instruction size. Bit 0 of `linkData` is set when `curState` is 1 or 3. All other kinds never assert `linkWe`.
- R3: Kind 3 always changes state: from state 1 it goes to state 0, and from any other state it goes to state 1. The target is PC plus `immOffset`, with bit 0 cleared, and bit 1 also cleared when entering state 0.
- R4: Outside state 3, kinds 2 and 4 select state 1 when bit 0 of `regTarget` is 1 and state 0 when it is 0. The next PC is `regTarget` with bit 0 cleared, and bit 1 also cleared when the new state is 0.
- R5: Outside state 3, kind 5 moves to state 2 with next PC = `regTarget` with bit 0 cleared.
- R6: In state 3, kinds 2, 4 and 5 stay in state 3 and all behave as a plain register transfer. Kind 5 acts exactly like kind 2. If bit 0 of `regTarget` is 0, the operation faults.
- R7: In state 3, kind 3 always faults.
- R8: A displacement outside its range faults. In states 0 and 2 the range is [-2^25, 2^25-1]. In states 1 and 3 the ranges are:
  - kinds 1 and 3: [-2^24, 2^24-1];
  - kind 0, 2-byte, unconditional: [-2^11, 2^11-1];
  - kind 0, 2-byte, conditional: [-252, 258];
  - kind 0, 4-byte, conditional: [-2^20, 2^20-1];
  - kind 0, 4-byte, unconditional: [-2^24, 2^24-1].
- R9: A fault (including kinds 6 and 7) gives `brTaken`=0, `linkWe`=0, sequential `nextPc` and unchanged state. Faults are raised only when the condition passes.
- R10: The instruction size is 4 bytes in states 0 and 2, regardless of `instrWide`. In states 1 and 3 it is 4 when `instrWide`=1 and 2 otherwise.
- R11: During reset, and in any cycle after one with `opValid`=0, `resultValid`, `brTaken`, `linkWe` and `fault` are 0.
- R12: Kinds 0 and 1, when taken, go to PC plus `immOffset` (bit 0 cleared) and keep the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is present this cycle |
| opKind | input | 3 | Operation kind |
| condCode | input | 4 | Condition code |
| condFlags | input | 4 | Current flags, negative/zero/carry/overflow |
| curState | input | 2 | Current execution state |
| curPc | input | 32 | Address of the operation |
| instrWide | input | 1 | Operation is 4 bytes long in the compact states |
| immOffset | input | 32 | Sign-extended byte displacement |
| regTarget | input | 32 | Register operand holding the target |
| resultValid | output | 1 | Registered copy of opValid |
| brTaken | output | 1 | Transfer happens |
| nextPc | output | 32 | Address to fetch next |
| nextState | output | 2 | Execution state after the operation |
| linkWe | output | 1 | Write the link register |
| linkData | output | 32 | Value for the link register |
| fault | output | 1 | Operation rejected |

## Verification
Each result is registered once, so a wrong decision inside the control shows up on the very next cycle. It appears as a wrong state code, a link strobe on a non-call kind, or a taken flag paired with a fault. A slip in the target arithmetic appears in the same cycle as low PC bits that should have been cleared, or as a fall-through address that disagrees with the link value. The state selection depends on one register bit and on the current state, so the sweep covers every kind against every state, both size settings and all four low-bit patterns of the register target. The range limits are probed on both sides of each edge.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [2:0] {
    OP_JUMP          = 3'd0,
    OP_CALL          = 3'd1,
    OP_JUMP_REG      = 3'd2,
    OP_CALL_SWAP     = 3'd3,
    OP_CALL_REG      = 3'd4,
    OP_JUMP_BYTECODE = 3'd5,
    OP_BAD6          = 3'd6,
    OP_BAD7          = 3'd7
  } brOp_e;

  typedef enum logic [1:0] {
    ST_FIXED    = 2'd0,
    ST_COMPACT  = 2'd1,
    ST_BYTECODE = 2'd2,
    ST_EXT      = 2'd3
  } exState_e;

  typedef enum logic [1:0] {
    PC_SEQ = 2'd0,
    PC_IMM = 2'd1,
    PC_REG = 2'd2
  } pcSel_e;

  typedef enum logic [2:0] {
    RG_NONE    = 3'd0,
    RG_FIXED   = 3'd1,
    RG_C16     = 3'd2,
    RG_C16COND = 3'd3,
    RG_C32COND = 3'd4,
    RG_C32     = 3'd5
  } rangeCls_e;

  typedef struct packed {
    logic     taken;
    logic     linkWe;
    logic     fault;
    logic     linkOdd;
    logic     clrBit1;
    logic     longInstr;
    pcSel_e   pcSel;
    exState_e nextState;
  } brStrobe_t;

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval (
  input  logic [3:0] condCode,
  input  logic [3:0] condFlags,
  output logic       condPass,
  output logic       condAlways
);
  logic flagN, flagZ, flagC, flagV;

  always_comb begin
    flagN = condFlags[3];
    flagZ = condFlags[2];
    flagC = condFlags[1];
    flagV = condFlags[0];
    condAlways = (condCode == 4'd14) || (condCode == 4'd15);
    unique case (condCode)
      4'd0:    condPass = flagZ;
      4'd1:    condPass = !flagZ;
      4'd2:    condPass = flagC;
      4'd3:    condPass = !flagC;
      4'd4:    condPass = flagN;
      4'd5:    condPass = !flagN;
      4'd6:    condPass = flagV;
      4'd7:    condPass = !flagV;
      4'd8:    condPass = flagC && !flagZ;
      4'd9:    condPass = !flagC || flagZ;
      4'd10:   condPass = (flagN == flagV);
      4'd11:   condPass = (flagN != flagV);
      4'd12:   condPass = !flagZ && (flagN == flagV);
      4'd13:   condPass = flagZ || (flagN != flagV);
      default: condPass = 1'b1;
    endcase
  end
endmodule

// File: rtl/br_range_check.sv
module br_range_check
  import br_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIXED_LOG2 = 25,
  parameter int C16_LOG2   = 11,
  parameter int C32C_LOG2  = 20,
  parameter int C32_LOG2   = 24,
  parameter int C16C_MIN   = -252,
  parameter int C16C_MAX   = 258
) (
  input  logic [2:0]        opKind,
  input  logic [1:0]        curState,
  input  logic              instrWide,
  input  logic              condAlways,
  input  logic [ADDR_W-1:0] immOffset,
  output logic              inRange
);
  localparam int XW = ADDR_W + 1;
  localparam logic signed [XW-1:0] FIXED_HI = XW'((64'sd1 <<< FIXED_LOG2) - 1);
  localparam logic signed [XW-1:0] FIXED_LO = -FIXED_HI - 1;
  localparam logic signed [XW-1:0] C16_HI   = XW'((64'sd1 <<< C16_LOG2) - 1);
  localparam logic signed [XW-1:0] C16_LO   = -C16_HI - 1;
  localparam logic signed [XW-1:0] C32C_HI  = XW'((64'sd1 <<< C32C_LOG2) - 1);
  localparam logic signed [XW-1:0] C32C_LO  = -C32C_HI - 1;
  localparam logic signed [XW-1:0] C32_HI   = XW'((64'sd1 <<< C32_LOG2) - 1);
  localparam logic signed [XW-1:0] C32_LO   = -C32_HI - 1;
  localparam logic signed [XW-1:0] C16C_HI  = XW'(C16C_MAX);
  localparam logic signed [XW-1:0] C16C_LO  = XW'(C16C_MIN);

  rangeCls_e rangeCls;
  logic signed [XW-1:0] offX;
  logic signed [XW-1:0] loLim, hiLim;
  logic compactSt;

  always_comb begin
    compactSt = (curState == ST_COMPACT) || (curState == ST_EXT);
    rangeCls  = RG_NONE;
    unique case (brOp_e'(opKind))
      OP_JUMP: begin
        if (!compactSt)       rangeCls = RG_FIXED;
        else if (instrWide)   rangeCls = condAlways ? RG_C32 : RG_C32COND;
        else                  rangeCls = condAlways ? RG_C16 : RG_C16COND;
      end
      OP_CALL, OP_CALL_SWAP: rangeCls = compactSt ? RG_C32 : RG_FIXED;
      default:               rangeCls = RG_NONE;
    endcase
  end

  always_comb begin
    offX = {immOffset[ADDR_W-1], immOffset};
    unique case (rangeCls)
      RG_FIXED:   begin loLim = FIXED_LO; hiLim = FIXED_HI; end
      RG_C16:     begin loLim = C16_LO;   hiLim = C16_HI;   end
      RG_C16COND: begin loLim = C16C_LO;  hiLim = C16C_HI;  end
      RG_C32COND: begin loLim = C32C_LO;  hiLim = C32C_HI;  end
      RG_C32:     begin loLim = C32_LO;   hiLim = C32_HI;   end
      default:    begin loLim = '0;       hiLim = '0;       end
    endcase
    inRange = (rangeCls == RG_NONE) || ((offX >= loLim) && (offX <= hiLim));
  end
endmodule

// File: rtl/br_ctrl.sv
module br_ctrl
  import br_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opKind,
  input  logic [1:0] curState,
  input  logic       instrWide,
  input  logic       condPass,
  input  logic       inRange,
  input  logic       regBit0,
  output brStrobe_t  strobes
);
  exState_e stateIn;
  brOp_e    op;
  logic     compactSt;
  logic     extSt;

  always_comb begin
    stateIn   = exState_e'(curState);
    op        = brOp_e'(opKind);
    compactSt = (stateIn == ST_COMPACT) || (stateIn == ST_EXT);
    extSt     = (stateIn == ST_EXT);

    strobes           = '0;
    strobes.pcSel     = PC_SEQ;
    strobes.nextState = stateIn;
    strobes.linkOdd   = compactSt;
    strobes.longInstr = !compactSt || instrWide;

    if (opValid && condPass) begin
      unique case (op)
        OP_JUMP, OP_CALL: begin
          if (!inRange) begin
            strobes.fault = 1'b1;
          end else begin
            strobes.taken  = 1'b1;
            strobes.pcSel  = PC_IMM;
            strobes.linkWe = (op == OP_CALL);
          end
        end
        OP_CALL_SWAP: begin
          if (extSt || !inRange) begin
            strobes.fault = 1'b1;
          end else begin
            strobes.taken     = 1'b1;
            strobes.linkWe    = 1'b1;
            strobes.pcSel     = PC_IMM;
            strobes.nextState = (stateIn == ST_COMPACT) ? ST_FIXED : ST_COMPACT;
            strobes.clrBit1   = (stateIn == ST_COMPACT);
          end
        end
        OP_JUMP_REG, OP_CALL_REG, OP_JUMP_BYTECODE: begin
          if (extSt) begin
            if (!regBit0) begin
              strobes.fault = 1'b1;
            end else begin
              strobes.taken     = 1'b1;
              strobes.pcSel     = PC_REG;
              strobes.linkWe    = (op == OP_CALL_REG);
              strobes.nextState = ST_EXT;
            end
          end else begin
            strobes.taken  = 1'b1;
            strobes.pcSel  = PC_REG;
            strobes.linkWe = (op == OP_CALL_REG);
            if (op == OP_JUMP_BYTECODE) begin
              strobes.nextState = ST_BYTECODE;
            end else begin
              strobes.nextState = regBit0 ? ST_COMPACT : ST_FIXED;
              strobes.clrBit1   = !regBit0;
            end
          end
        end
        default: strobes.fault = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/br_datapath.sv
module br_datapath
  import br_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] immOffset,
  input  logic [ADDR_W-1:0] regTarget,
  input  brStrobe_t         strobes,
  output logic              resultValid,
  output logic              brTaken,
  output logic [ADDR_W-1:0] nextPc,
  output logic [1:0]        nextState,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData,
  output logic              fault
);
  localparam logic [ADDR_W-1:0] STEP_SHORT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_LONG  = ADDR_W'(4);

  logic [ADDR_W-1:0] seqPc, immPc, rawTgt, tgtPc, pcD, linkD;

  always_comb begin
    seqPc = curPc + (strobes.longInstr ? STEP_LONG : STEP_SHORT);
    immPc = curPc + immOffset;
    unique case (strobes.pcSel)
      PC_IMM:  rawTgt = immPc;
      PC_REG:  rawTgt = regTarget;
      default: rawTgt = seqPc;
    endcase
    tgtPc    = rawTgt;
    tgtPc[0] = 1'b0;
    if (strobes.clrBit1) tgtPc[1] = 1'b0;
    pcD      = strobes.taken ? tgtPc : seqPc;
    linkD    = seqPc | ADDR_W'(strobes.linkOdd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      brTaken     <= 1'b0;
      linkWe      <= 1'b0;
      fault       <= 1'b0;
      nextPc      <= '0;
      nextState   <= ST_FIXED;
      linkData    <= '0;
    end else begin
      resultValid <= opValid;
      brTaken     <= strobes.taken;
      linkWe      <= strobes.linkWe;
      fault       <= strobes.fault;
      nextPc      <= pcD;
      nextState   <= strobes.nextState;
      linkData    <= linkD;
    end
  end

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!brTaken && !linkWe));

  // R1
  fallthru_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !brTaken) |-> (nextPc == {linkData[ADDR_W-1:1], 1'b0}));

  // R4
  target_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |-> (nextPc[0] == 1'b0));
endmodule

// File: rtl/br_resolve_top.sv
module br_resolve_top
  import br_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic [3:0]        condCode,
  input  logic [3:0]        condFlags,
  input  logic [1:0]        curState,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              instrWide,
  input  logic [ADDR_W-1:0] immOffset,
  input  logic [ADDR_W-1:0] regTarget,
  output logic              resultValid,
  output logic              brTaken,
  output logic [ADDR_W-1:0] nextPc,
  output logic [1:0]        nextState,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData,
  output logic              fault
);
  logic      condPass, condAlways, inRange;
  brStrobe_t strobes;

  br_cond_eval uCond (
    .condCode  (condCode),
    .condFlags (condFlags),
    .condPass  (condPass),
    .condAlways(condAlways)
  );

  br_range_check #(.ADDR_W(ADDR_W)) uRange (
    .opKind    (opKind),
    .curState  (curState),
    .instrWide (instrWide),
    .condAlways(condAlways),
    .immOffset (immOffset),
    .inRange   (inRange)
  );

  br_ctrl uCtrl (
    .opValid  (opValid),
    .opKind   (opKind),
    .curState (curState),
    .instrWide(instrWide),
    .condPass (condPass),
    .inRange  (inRange),
    .regBit0  (regTarget[0]),
    .strobes  (strobes)
  );

  br_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .curPc      (curPc),
    .immOffset  (immOffset),
    .regTarget  (regTarget),
    .strobes    (strobes),
    .resultValid(resultValid),
    .brTaken    (brTaken),
    .nextPc     (nextPc),
    .nextState  (nextState),
    .linkWe     (linkWe),
    .linkData   (linkData),
    .fault      (fault)
  );

  // R3
  swap_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brTaken && $past(opKind) == 3'd3) |-> (nextState != $past(curState)));

  // R6
  ext_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brTaken && $past(curState) == 2'd3) |-> (nextState == 2'd3));

  // R9
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !brTaken) |-> (nextState == $past(curState)));

  // R2
  link_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> ($past(opKind) == 3'd1 || $past(opKind) == 3'd3 || $past(opKind) == 3'd4));

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> (!brTaken && !linkWe && !fault));
endmodule

// File: tb/br_resolve_top_test.sv
module br_resolve_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opKind = '0;
  logic [3:0]  condCode = 4'd14;
  logic [3:0]  condFlags = '0;
  logic [1:0]  curState = '0;
  logic [31:0] curPc = '0;
  logic        instrWide = 1'b0;
  logic [31:0] immOffset = '0;
  logic [31:0] regTarget = '0;
  logic        resultValid, brTaken, linkWe, fault;
  logic [31:0] nextPc, linkData;
  logic [1:0]  nextState;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5ns clk = ~clk;

  br_resolve_top uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .condCode(condCode), .condFlags(condFlags), .curState(curState),
    .curPc(curPc), .instrWide(instrWide), .immOffset(immOffset),
    .regTarget(regTarget), .resultValid(resultValid), .brTaken(brTaken),
    .nextPc(nextPc), .nextState(nextState), .linkWe(linkWe),
    .linkData(linkData), .fault(fault)
  );

  function automatic bit condOk(input int code, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (code)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c && !z;    9: return !c || z;
      10: return n == v;    11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  // Reference: {taken, linkWe, fault, state, pc, link}
  task automatic model(input int op, input int code, input logic [3:0] f,
                       input int st, input logic [31:0] pc, input bit wide,
                       input longint off, input logic [31:0] rg,
                       output bit eTaken, output bit eLink, output bit eFault,
                       output int eState, output logic [31:0] ePc,
                       output logic [31:0] eLinkData);
    bit compact = (st == 1 || st == 3);
    int size = (compact && !wide) ? 2 : 4;          // R10
    bit always_ = (code >= 14);
    longint lo, hi;
    logic [31:0] tgt;
    int k;
    eTaken = 0; eLink = 0; eFault = 0; eState = st;
    ePc = pc + size;
    eLinkData = (pc + size) | (compact ? 32'd1 : 32'd0);
    tgt = pc + 32'(off);
    if (!compact) k = 25;
    else if (op == 1 || op == 3) k = 24;
    else if (wide) k = always_ ? 24 : 20;
    else k = always_ ? 11 : 0;
    if (k == 0) begin lo = -252; hi = 258; end
    else begin lo = -(64'sd1 <<< k); hi = (64'sd1 <<< k) - 1; end
    if (!condOk(code, f)) return;
    case (op)
      0, 1: begin
        if (off < lo || off > hi) eFault = 1;
        else begin eTaken = 1; eLink = (op == 1); ePc = tgt & ~32'd1; end
      end
      3: begin
        if (st == 3 || off < lo || off > hi) eFault = 1;
        else begin
          eTaken = 1; eLink = 1;
          eState = (st == 1) ? 0 : 1;
          ePc = tgt & ((eState == 0) ? ~32'd3 : ~32'd1);
        end
      end
      2, 4, 5: begin
        if (st == 3) begin
          if (!rg[0]) eFault = 1;
          else begin eTaken = 1; eLink = (op == 4); eState = 3; ePc = rg & ~32'd1; end
        end else begin
          eTaken = 1; eLink = (op == 4);
          if (op == 5) begin eState = 2; ePc = rg & ~32'd1; end
          else begin eState = rg[0] ? 1 : 0; ePc = rg & (rg[0] ? ~32'd1 : ~32'd3); end
        end
      end
      default: eFault = 1;
    endcase
  endtask

  task automatic runOp(input string req, input int op, input int code,
                       input logic [3:0] f, input int st, input logic [31:0] pc,
                       input bit wide, input longint off, input logic [31:0] rg);
    bit eT, eL, eF; int eS; logic [31:0] eP, eD;
    model(op, code, f, st, pc, wide, off, rg, eT, eL, eF, eS, eP, eD);
    @(negedge clk);
    opValid = 1; opKind = 3'(op); condCode = 4'(code); condFlags = f;
    curState = 2'(st); curPc = pc; instrWide = wide;
    immOffset = 32'(off); regTarget = rg;
    @(posedge clk); #1;
    total++;
    if (!resultValid || brTaken !== eT || linkWe !== eL || fault !== eF ||
        nextState !== 2'(eS) || nextPc !== eP || (eL && linkData !== eD)) begin
      bad++;
      $display("FAIL %s op=%0d st=%0d cond=%0d: got t=%0b l=%0b f=%0b s=%0d pc=%h ld=%h exp t=%0b l=%0b f=%0b s=%0d pc=%h ld=%h",
               req, op, st, code, brTaken, linkWe, fault, nextState, nextPc, linkData,
               eT, eL, eF, eS, eP, eD);
    end
  endtask

  task automatic checkIdle(input string req);
    @(negedge clk);
    opValid = 0; opKind = 3'd3; regTarget = 32'h1;
    @(posedge clk); #1;
    total++;
    if (resultValid !== 0 || brTaken !== 0 || linkWe !== 0 || fault !== 0) begin
      bad++;
      $display("FAIL %s idle: got v=%0b t=%0b l=%0b f=%0b exp all 0",
               req, resultValid, brTaken, linkWe, fault);
    end
  endtask

  task automatic rangeEdges(input string req, input int op, input int code,
                            input int st, input bit wide, input longint lo, input longint hi);
    runOp(req, op, code, 4'b0100, st, 32'h0400_0000, wide, lo - 2, 32'h0);
    runOp(req, op, code, 4'b0100, st, 32'h0400_0000, wide, lo, 32'h0);
    runOp(req, op, code, 4'b0100, st, 32'h0400_0000, wide, hi - 1, 32'h0);
    runOp(req, op, code, 4'b0100, st, 32'h0400_0000, wide, hi + 1, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (resultValid !== 0 || brTaken !== 0 || linkWe !== 0 || fault !== 0) begin
      bad++;
      $display("FAIL R11 reset: got v=%0b t=%0b l=%0b f=%0b exp all 0",
               resultValid, brTaken, linkWe, fault);
    end
    @(negedge clk); rstN = 1;

    // R1: every condition code against every flag pattern
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        runOp("R1", (c % 2) ? 1 : 0, c, 4'(f), 1, 32'h0000_8000, 1'b1, 64'sd256, 32'h0);

    checkIdle("R11");

    // R2 R3 R4 R5 R6 R7 R10 R12: kinds x states x size x low target bits
    for (int op = 0; op < 8; op++)
      for (int st = 0; st < 4; st++)
        for (int w = 0; w < 2; w++)
          for (int rb = 0; rb < 4; rb++)
            runOp((op == 3) ? ((st == 3) ? "R7" : "R3") :
                  (op == 5) ? ((st == 3) ? "R6" : "R5") :
                  (op == 2 || op == 4) ? ((st == 3) ? "R6" : "R4") :
                  (op >= 6) ? "R9" : "R12",
                  op, 14, 4'b0, st, 32'h0001_0002 + 32'(rb * 16), w[0],
                  64'sd64 + 64'(rb * 2), 32'h0004_2000 | 32'(rb));

    // R2: link data with conditional calls, negative offsets
    runOp("R2", 1, 0, 4'b0100, 0, 32'h0002_0000, 1'b0, -64'sd4096, 32'h0);
    runOp("R2", 1, 1, 4'b0100, 1, 32'h0002_0000, 1'b0, -64'sd4096, 32'h0);
    runOp("R2", 4, 10, 4'b1001, 3, 32'h0002_0010, 1'b0, 64'sd0, 32'h0003_0007);

    // R8: range edges for every class
    rangeEdges("R8", 0, 14, 0, 1'b0, -(64'sd1 <<< 25), (64'sd1 <<< 25) - 1);
    rangeEdges("R8", 1, 14, 2, 1'b1, -(64'sd1 <<< 25), (64'sd1 <<< 25) - 1);
    rangeEdges("R8", 0, 14, 1, 1'b0, -(64'sd1 <<< 11), (64'sd1 <<< 11) - 1);
    rangeEdges("R8", 0, 0, 1, 1'b0, -64'sd252, 64'sd258 + 1);
    rangeEdges("R8", 0, 0, 3, 1'b1, -(64'sd1 <<< 20), (64'sd1 <<< 20) - 1);
    rangeEdges("R8", 0, 15, 1, 1'b1, -(64'sd1 <<< 24), (64'sd1 <<< 24) - 1);
    rangeEdges("R8", 1, 14, 1, 1'b0, -(64'sd1 <<< 24), (64'sd1 <<< 24) - 1);
    rangeEdges("R8", 3, 14, 0, 1'b0, -(64'sd1 <<< 25), (64'sd1 <<< 25) - 1);

    // R9: out-of-range or bad target with failing condition raises no fault
    runOp("R9", 0, 0, 4'b0000, 0, 32'h1000, 1'b0, 64'sd1 <<< 27, 32'h0);
    runOp("R9", 3, 1, 4'b0100, 3, 32'h1000, 1'b0, 64'sd8, 32'h0);
    runOp("R9", 2, 2, 4'b0000, 3, 32'h1000, 1'b1, 64'sd0, 32'h2000);
    runOp("R9", 6, 14, 4'b0000, 1, 32'h1000, 1'b0, 64'sd0, 32'h0);

    checkIdle("R11");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no completion, exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule